// File: doc/BRIEF.md
# Interrupt Enable and Flag Register

This block holds the eight-bit enable and flag register that sits in front of a small processor core's interrupt logic. Three core sources are tracked: a timer rollover, an external edge event and a change on any of a set of port pins. Each has a sticky flag and an enable bit. A fourth, peripheral, request arrives already latched elsewhere and only needs gating. Hardware sets a flag from a one-cycle event pulse whether or not that source is enabled. Software reads the whole register and writes it back to clear flags or change enables.

The block raises one combinational request line. The request is gated first by a per-source enable, or by the peripheral enable for the peripheral line, and then by a global enable. When the core accepts the interrupt it pulses an acknowledge strobe. The block then drops the global enable so nested entry cannot happen, and it drives a fixed vector address. A return strobe sets the global enable again.

Top module: `irq_ctrl_reg`

## Requirements
- R1: After reset, rd_data reads 8'h00 and irq_req is 0.
- R2: rd_data shows the register with bit 7 global enable, bit 6 peripheral enable, bit 5 timer enable, bit 4 external enable, bit 3 pin-change enable, bit 2 timer flag, bit 1 external flag and bit 0 pin-change flag. A write with wr_en high loads all eight bits from wr_data, and rd_data shows them on the next cycle.
- R3: A pulse on tmr_roll sets bit 2, and a pulse on ext_evt sets bit 1, one cycle later. The state of every enable bit has no effect on this.
- R4: Bit 0 is set one cycle after any pin whose pin_mask bit is 1 reports pin_chg high. A change on a pin whose mask bit is 0 leaves bit 0 unchanged.
- R5: Once set, a flag stays set until a software write puts 0 in it. Neither idle cycles nor irq_ack clear a flag.
- R6: When a hardware set event and a software write of 0 hit the same flag in one cycle, the flag ends up 1. The other bits take the written value.
- R7: In the same cycle, irq_req = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND periph_req)).
- R8: A pulse on irq_ack clears bit 7 on the next cycle and leaves bits 6..0 as they would otherwise be. irq_ack takes priority over irq_ret and over a write to bit 7.
- R9: A pulse on irq_ret without irq_ack sets bit 7 on the next cycle. It takes priority over a write of 0 to bit 7.
- R10: vec_addr always equals the parameter VECTOR_ADDR, which defaults to 13'h0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write value |
| rd_data | output | 8 | Current register value |
| tmr_roll | input | 1 | Timer rollover event pulse |
| ext_evt | input | 1 | External edge event pulse |
| pin_chg | input | NPINS | Per-pin change detected |
| pin_mask | input | NPINS | Per-pin change enable mask |
| periph_req | input | 1 | Combined peripheral request level |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| vec_addr | output | VEC_W | Interrupt vector address |

## Verification
The request gate is swept over all 256 register values with the peripheral line both low and high. A wrong operand or a missing level of gating would raise or drop irq_req for some of those values. All 256 pin change and mask pairs are applied to a four-pin configuration, which catches a flag that ignores the mask or looks at only some pins. Same-cycle collisions get their own checks: a write of 0 together with a hardware set, acknowledge together with return and a write, and return together with a write. A priority in the wrong order would leave a flag lost or the global enable stuck high after an acknowledge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int REG_W       = 8;
   localparam int NUM_FLG     = 3;
   localparam int NUM_EN      = 5;
   // enable vector index (bits 7..3 of the register)
   localparam int EN_GLB      = 4;
   localparam int EN_PER      = 3;
   localparam int EN_TMR      = 2;
   localparam int EN_EXT      = 1;
   localparam int EN_PIN      = 0;
   // flag vector index (bits 2..0 of the register)
   localparam int FL_TMR      = 2;
   localparam int FL_EXT      = 1;
   localparam int FL_PIN      = 0;
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
   parameter int NPINS = 4
) (
   input  logic [NPINS-1:0] pin_chg,
   input  logic [NPINS-1:0] pin_mask,
   output logic             any_chg
);
   logic [NPINS-1:0] hit;

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         assign hit[p] = pin_chg[p] & pin_mask[p];
      end
   endgenerate

   assign any_chg = |hit;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [N-1:0] wr_bits,
   input  logic [N-1:0] set,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (wr_en)  q[i] <= wr_bits[i];
         end

         AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !wr_en) |=> q[i]); // R5
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]); // R6
      end
   endgenerate
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
   import irq_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NUM_EN-1:0] wr_bits,
   input  logic              irq_ack,
   input  logic              irq_ret,
   output logic [NUM_EN-1:0] en_q
);
   generate
      for (genvar i = 0; i < NUM_EN; i++) begin : g_en
         if (i == EN_GLB) begin : g_glb
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       en_q[i] <= 1'b0;
               else if (irq_ack) en_q[i] <= 1'b0;
               else if (irq_ret) en_q[i] <= 1'b1;
               else if (wr_en)   en_q[i] <= wr_bits[i];
            end
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)     en_q[i] <= 1'b0;
               else if (wr_en) en_q[i] <= wr_bits[i];
            end
         end
      end
   endgenerate

   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !en_q[EN_GLB]); // R8
   AST_RET_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_ack) |=> en_q[EN_GLB]); // R9
endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate
   import irq_ctrl_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EN-1:0]  en,
   input  logic [NUM_FLG-1:0] flg,
   input  logic               periph_req,
   output logic               irq_req
);
   logic core_any;
   logic per_any;

   assign core_any = (en[EN_TMR] & flg[FL_TMR]) |
                     (en[EN_EXT] & flg[FL_EXT]) |
                     (en[EN_PIN] & flg[FL_PIN]);
   assign per_any  = en[EN_PER] & periph_req;
   assign irq_req  = en[EN_GLB] & (core_any | per_any);

   AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !en[EN_GLB] |-> !irq_req); // R7
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
   import irq_ctrl_pkg::*;
#(
   parameter int NPINS       = 4,
   parameter int VEC_W       = 13,
   parameter int VECTOR_ADDR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   output logic [7:0]       rd_data,
   input  logic             tmr_roll,
   input  logic             ext_evt,
   input  logic [NPINS-1:0] pin_chg,
   input  logic [NPINS-1:0] pin_mask,
   input  logic             periph_req,
   input  logic             irq_ack,
   input  logic             irq_ret,
   output logic             irq_req,
   output logic [VEC_W-1:0] vec_addr
);
   generate
      if (NPINS < 1) begin : g_bad_pins
         $error("irq_ctrl_reg: NPINS must be at least 1");
      end
      if (VEC_W < 3 || VEC_W > 31) begin : g_bad_vw
         $error("irq_ctrl_reg: VEC_W out of range");
      end
      if (VECTOR_ADDR < 0 || VECTOR_ADDR >= (1 << VEC_W)) begin : g_bad_vec
         $error("irq_ctrl_reg: VECTOR_ADDR does not fit VEC_W");
      end
   endgenerate

   logic [NUM_EN-1:0]  en_q;
   logic [NUM_FLG-1:0] flg_q;
   logic [NUM_FLG-1:0] flg_set;
   logic               pin_any;

   irq_pin_detect #(.NPINS(NPINS)) u_pins (
      .pin_chg (pin_chg),
      .pin_mask(pin_mask),
      .any_chg (pin_any)
   );

   always_comb begin
      flg_set         = '0;
      flg_set[FL_TMR] = tmr_roll;
      flg_set[FL_EXT] = ext_evt;
      flg_set[FL_PIN] = pin_any;
   end

   irq_flag_bank #(.N(NUM_FLG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_bits(wr_data[NUM_FLG-1:0]),
      .set    (flg_set),
      .q      (flg_q)
   );

   irq_enable_bank u_enables (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_bits(wr_data[REG_W-1:NUM_FLG]),
      .irq_ack(irq_ack),
      .irq_ret(irq_ret),
      .en_q   (en_q)
   );

   irq_req_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .flg       (flg_q),
      .periph_req(periph_req),
      .irq_req   (irq_req)
   );

   assign rd_data  = {en_q, flg_q};
   assign vec_addr = VEC_W'(VECTOR_ADDR);

   AST_ACK_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !wr_en) |=> (rd_data[NUM_FLG-1:0] & $past(rd_data[NUM_FLG-1:0]))
                              == $past(rd_data[NUM_FLG-1:0])); // R5
endmodule

// File: tb/irq_ctrl_reg_tb.sv
module irq_ctrl_reg_tb;
   localparam int NP = 4;
   localparam int VW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_data;
   logic          tmr_roll = 1'b0;
   logic          ext_evt = 1'b0;
   logic [NP-1:0] pin_chg = '0;
   logic [NP-1:0] pin_mask = '0;
   logic          periph_req = 1'b0;
   logic          irq_ack = 1'b0;
   logic          irq_ret = 1'b0;
   logic          irq_req;
   logic [VW-1:0] vec_addr;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   irq_ctrl_reg #(.NPINS(NP), .VEC_W(VW), .VECTOR_ADDR(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .tmr_roll(tmr_roll), .ext_evt(ext_evt),
      .pin_chg(pin_chg), .pin_mask(pin_mask), .periph_req(periph_req),
      .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
      .vec_addr(vec_addr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // advance one clock, return just after the edge; all drives happen here
   task automatic step();
      @(posedge clk);
      #2;
      wr_en = 1'b0; tmr_roll = 1'b0; ext_evt = 1'b0; pin_chg = '0;
      irq_ack = 1'b0; irq_ret = 1'b0;
   endtask

   task automatic wr(input logic [7:0] v);
      wr_en = 1'b1; wr_data = v;
      step();
   endtask

   initial begin
      #(20 * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #35;
      rst_n = 1'b1;
      step();
      // R1 reset state, R10 vector
      chk("R1 rd_data", 32'(rd_data), 32'h00);
      chk("R1 irq_req", 32'(irq_req), 32'h0);
      chk("R10 vec_addr", 32'(vec_addr), 32'h4);

      // R2 write/read layout
      wr(8'hA5); chk("R2 rd A5", 32'(rd_data), 32'hA5);
      wr(8'h5A); chk("R2 rd 5A", 32'(rd_data), 32'h5A);
      wr(8'h00); chk("R2 rd 00", 32'(rd_data), 32'h00);

      // R3 flags set with all enables at 0
      tmr_roll = 1'b1; step(); chk("R3 timer flag", 32'(rd_data), 32'h04);
      ext_evt = 1'b1;  step(); chk("R3 external flag", 32'(rd_data), 32'h06);
      pin_mask = 4'b0100; pin_chg = 4'b0100; step();
      chk("R4 pin flag", 32'(rd_data), 32'h07);
      chk("R3 no request while disabled", 32'(irq_req), 32'h0);

      // R5 sticky, ack does not clear flags
      step(); step();
      chk("R5 flags hold", 32'(rd_data), 32'h07);
      irq_ack = 1'b1; step();
      chk("R5 ack keeps flags", 32'(rd_data), 32'h07);
      wr(8'h00); chk("R5 write clears", 32'(rd_data), 32'h00);

      // R4 exhaustive pin/mask sweep
      for (int c = 0; c < 16; c++) begin
         for (int m = 0; m < 16; m++) begin
            wr(8'h00);
            pin_chg = 4'(c); pin_mask = 4'(m);
            step();
            chk("R4 pin sweep", 32'(rd_data), 32'(((c & m) != 0) ? 1 : 0));
         end
      end
      pin_mask = '0;

      // R6 hardware set beats write of zero
      wr(8'h04);
      wr_en = 1'b1; wr_data = 8'h00; tmr_roll = 1'b1; step();
      chk("R6 timer set wins", 32'(rd_data), 32'h04);
      wr_en = 1'b1; wr_data = 8'h80; ext_evt = 1'b1; step();
      chk("R6 ext set wins, others written", 32'(rd_data), 32'h82);

      // R7 exhaustive request gate sweep
      for (int v = 0; v < 256; v++) begin
         for (int p = 0; p < 2; p++) begin
            wr(8'(v));
            periph_req = p[0];
            #1;
            chk("R7 request gate", 32'(irq_req),
                32'(v[7] & ((v[5] & v[2]) | (v[4] & v[1]) | (v[3] & v[0]) | (v[6] & p[0]))));
            periph_req = 1'b0;
         end
      end

      // R8 ack clears global enable only
      wr(8'hFF);
      chk("R7 request active", 32'(irq_req), 32'h1);
      irq_ack = 1'b1; step();
      chk("R8 ack clears global", 32'(rd_data), 32'h7F);
      chk("R8 request dropped", 32'(irq_req), 32'h0);
      irq_ret = 1'b1; irq_ack = 1'b1; wr_en = 1'b1; wr_data = 8'hFF; step();
      chk("R8 ack beats ret and write", 32'(rd_data), 32'h7F);

      // R9 return sets global enable
      irq_ret = 1'b1; step();
      chk("R9 ret sets global", 32'(rd_data), 32'hFF);
      irq_ret = 1'b1; wr_en = 1'b1; wr_data = 8'h71; step();
      chk("R9 ret beats write", 32'(rd_data), 32'hF1);
      chk("R10 vec_addr hold", 32'(vec_addr), 32'h4);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule